// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block sits at the last stage of an in-order pipeline and decides what happens to each instruction that reaches it. Every stage may report a fault for the instruction it holds. The unit keeps the fault from the earliest stage as the instruction's cause, checks the external interrupt line, and then takes one of three actions. It can let the instruction retire. It can take a trap, which loads the saved-PC, cause and mode-stack registers and steers fetch to the trap vector. It can return from a trap, which pops the mode stack and steers fetch to the saved PC. Each redirect flips an epoch bit. Younger instructions that still carry the old epoch are then dropped when they arrive.

The unit also classifies the two system instructions. A system call traps with its own cause. A trap return is legal only in kernel mode; in user mode it becomes a no-permission fault, treated as if decode had reported it. All outputs are registered, so each result appears one clock after the instruction is presented.

Top module: `exc_commit_unit`

## Requirements
- R1: After synchronous reset: commit_en, sb_remove and redir_vld are 0; epc_q, cause_q and epoch are 0; status_q is 2'b01 (bit 0 = current mode, bit 1 = previous mode, 1 = kernel).
- R2: A live instruction (cm_valid=1 and cm_epoch equal to epoch) with no fault report, no interrupt and kind 0 (ordinary) or 3 (reserved, treated as ordinary) gives commit_en=1 and sb_remove=1 on the next cycle. It gives no redirect, and the CSRs are unchanged.
- R3: When several stage reports are valid, the cause taken is the code of the lowest-indexed stage (index 0 is the earliest stage). A no-permission fault counts as a report from the decode stage (index DEC_STAGE=1), and a real report from that stage wins over it.
- R4: A live faulting instruction with no interrupt gives commit_en=0 and loads epc_q with cm_pc and cause_q with the fault code. It pushes the mode stack (previous takes current, current becomes kernel) and redirects to TVEC. sb_remove=1 only if the winning stage index is at least RF_STAGE=2.
- R5: A live faulting instruction with ext_irq=1 is handled as in R4, except that cause_q becomes the interrupt code 0x00. Because epc_q holds cm_pc, the instruction runs again.
- R6: A live clean ordinary instruction with ext_irq=1 retires first (commit_en=1, sb_remove=1). epc_q then takes cm_ppc and cause_q takes 0x00, the mode stack is pushed, and fetch is redirected to TVEC.
- R7: A live clean system call (kind 1) with no interrupt gives commit_en=1 and sb_remove=1. It sets cause_q to 0x08 and epc_q to cm_pc, pushes the mode stack and redirects to TVEC.
- R8: A trap return (kind 2) in kernel mode retires, restores current mode from previous mode and redirects to the old epc_q. In user mode it traps with cause 0x0B. Other fault codes used: illegal opcode 0x0A, overflow 0x0C.
- R9: A live clean system call or legal trap return with ext_irq=1 does not retire (commit_en=0, sb_remove=0). The interrupt is taken with epc_q=cm_pc and cause_q=0x00, the mode stack is pushed, and fetch is redirected to TVEC.
- R10: Every redirect flips epoch in the same cycle. An instruction whose cm_epoch differs from epoch produces no strobe, no redirect and no CSR change.
- R11: ext_irq is ignored when no instruction is presented: no strobe, no redirect, and the CSRs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cm_valid | input | 1 | An instruction is presented at commit |
| cm_epoch | input | 1 | Epoch tag carried by the instruction |
| cm_pc | input | XLEN | PC of the instruction |
| cm_ppc | input | XLEN | Predicted next PC of the instruction |
| cm_kind | input | 2 | 0 ordinary, 1 system call, 2 trap return, 3 ordinary |
| flt_vld | input | NSTG | Per-stage fault report valid, index 0 earliest |
| flt_code | input | NSTG*CW | Per-stage fault code, stage s in bits [s*CW +: CW] |
| ext_irq | input | 1 | External interrupt request level |
| commit_en | output | 1 | Instruction retired |
| sb_remove | output | 1 | Clear the instruction's scoreboard entry |
| redir_vld | output | 1 | Fetch redirect strobe |
| redir_pc | output | XLEN | Redirect target, meaningful with redir_vld |
| epoch | output | 1 | Current epoch |
| epc_q | output | XLEN | Saved exception PC |
| cause_q | output | CW | Cause register |
| status_q | output | 2 | Mode stack {previous, current}, 1 = kernel |

## Verification
The bench pushes the unit through its priority corners. One case has a decode-stage no-permission fault together with an earlier fetch fault; a merge that picked the wrong stage would report 0x0B instead of 0x0A. Another has an interrupt meeting a clean instruction and then a faulting one; a unit that swapped the two would save the predicted successor where the instruction's own PC belongs, or would never re-execute the faulting instruction. It also checks scoreboard removal against the stage boundary: a design off by one stage would strobe for the decode-stage fault. Finally it sends an instruction with a stale epoch after a trap return, and sends an interrupt while the unit is idle; a unit that did not filter these would retire the dropped instruction or take an interrupt with no instruction to attach it to.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    K_ORD   = 2'd0,
    K_SCALL = 2'd1,
    K_ERET  = 2'd2,
    K_RSVD  = 2'd3
  } instr_kind_e;

  localparam int CODE_EXT    = 'h00;
  localparam int CODE_SCALL  = 'h08;
  localparam int CODE_ILLOP  = 'h0A;
  localparam int CODE_NOPERM = 'h0B;
  localparam int CODE_OVF    = 'h0C;

  typedef struct packed {
    logic prv;
    logic cur;
  } mode_stk_t;

  function automatic mode_stk_t stk_push(input mode_stk_t s);
    mode_stk_t r;
    r.prv = s.cur;
    r.cur = 1'b1;
    return r;
  endfunction

  function automatic mode_stk_t stk_pop(input mode_stk_t s);
    mode_stk_t r;
    r.cur = s.prv;
    r.prv = s.prv;
    return r;
  endfunction

endpackage

// File: rtl/exc_sys_classify.sv
module exc_sys_classify
  import exc_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       cur_kernel,
  output logic       is_scall,
  output logic       eret_ok,
  output logic       noperm
);

  instr_kind_e k;

  always_comb begin
    k        = instr_kind_e'(kind);
    is_scall = (k == K_SCALL);
    eret_ok  = (k == K_ERET) && cur_kernel;
    noperm   = (k == K_ERET) && !cur_kernel;
  end

endmodule

// File: rtl/exc_cause_merge.sv
module exc_cause_merge
  import exc_pkg::*;
#(
  parameter int NSTG      = 4,
  parameter int CW        = 5,
  parameter int DEC_STAGE = 1,
  localparam int SW       = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic [NSTG-1:0]    flt_vld,
  input  logic [NSTG*CW-1:0] flt_code,
  input  logic               noperm,
  output logic               any,
  output logic [CW-1:0]      code,
  output logic [SW-1:0]      stg
);

  logic [NSTG-1:0] v;
  logic [CW-1:0]   c [NSTG];

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    if (s == DEC_STAGE) begin : g_dec
      assign v[s] = flt_vld[s] | noperm;
      assign c[s] = flt_vld[s] ? flt_code[s*CW +: CW] : CW'(CODE_NOPERM);
    end else begin : g_plain
      assign v[s] = flt_vld[s];
      assign c[s] = flt_code[s*CW +: CW];
    end
  end

  // scan from the latest stage down so the earliest valid report is left standing
  always_comb begin
    any  = 1'b0;
    code = '0;
    stg  = '0;
    for (int s = NSTG - 1; s >= 0; s--) begin
      if (v[s]) begin
        any  = 1'b1;
        code = c[s];
        stg  = SW'(s);
      end
    end
  end

endmodule

// File: rtl/exc_csr_regs.sv
module exc_csr_regs
  import exc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_wr,
  input  logic [XLEN-1:0] epc_d,
  input  logic [CW-1:0]   cause_d,
  input  logic            do_pop,
  input  logic            flip,
  output logic [XLEN-1:0] epc_q,
  output logic [CW-1:0]   cause_q,
  output mode_stk_t       stk_q,
  output logic            epoch_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q   <= '0;
      cause_q <= '0;
      stk_q   <= '{prv: 1'b0, cur: 1'b1};
      epoch_q <= 1'b0;
    end else begin
      if (trap_wr) begin
        epc_q   <= epc_d;
        cause_q <= cause_d;
        stk_q   <= stk_push(stk_q);
      end else if (do_pop) begin
        stk_q   <= stk_pop(stk_q);
      end
      if (flip) epoch_q <= ~epoch_q;
    end
  end

endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
  import exc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          NSTG      = 4,
  parameter int          CW        = 5,
  parameter int          DEC_STAGE = 1,
  parameter int          RF_STAGE  = 2,
  parameter logic [31:0] TVEC      = 32'h0000_0100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cm_valid,
  input  logic               cm_epoch,
  input  logic [XLEN-1:0]    cm_pc,
  input  logic [XLEN-1:0]    cm_ppc,
  input  logic [1:0]         cm_kind,
  input  logic [NSTG-1:0]    flt_vld,
  input  logic [NSTG*CW-1:0] flt_code,
  input  logic               ext_irq,
  output logic               commit_en,
  output logic               sb_remove,
  output logic               redir_vld,
  output logic [XLEN-1:0]    redir_pc,
  output logic               epoch,
  output logic [XLEN-1:0]    epc_q,
  output logic [CW-1:0]      cause_q,
  output logic [1:0]         status_q
);

  localparam int SW = (NSTG > 1) ? $clog2(NSTG) : 1;

  mode_stk_t       stk;
  logic            is_scall, eret_ok, noperm;
  logic            f_any;
  logic [CW-1:0]   f_code;
  logic [SW-1:0]   f_stg;
  logic            live;

  logic            trap_wr, do_pop, commit_n, sbrm_n, redir_n;
  logic [XLEN-1:0] epc_d, rtgt_n;
  logic [CW-1:0]   cause_d;

  exc_sys_classify i_cls (
    .kind       (cm_kind),
    .cur_kernel (stk.cur),
    .is_scall   (is_scall),
    .eret_ok    (eret_ok),
    .noperm     (noperm)
  );

  exc_cause_merge #(.NSTG(NSTG), .CW(CW), .DEC_STAGE(DEC_STAGE)) i_merge (
    .flt_vld  (flt_vld),
    .flt_code (flt_code),
    .noperm   (noperm),
    .any      (f_any),
    .code     (f_code),
    .stg      (f_stg)
  );

  exc_csr_regs #(.XLEN(XLEN), .CW(CW)) i_csr (
    .clk     (clk),
    .rst     (rst),
    .trap_wr (trap_wr),
    .epc_d   (epc_d),
    .cause_d (cause_d),
    .do_pop  (do_pop),
    .flip    (redir_n),
    .epc_q   (epc_q),
    .cause_q (cause_q),
    .stk_q   (stk),
    .epoch_q (epoch)
  );

  assign live     = cm_valid && (cm_epoch == epoch);
  assign status_q = {stk.prv, stk.cur};

  always_comb begin
    trap_wr  = 1'b0;
    do_pop   = 1'b0;
    commit_n = 1'b0;
    sbrm_n   = 1'b0;
    redir_n  = 1'b0;
    epc_d    = cm_pc;
    cause_d  = CW'(CODE_EXT);
    rtgt_n   = XLEN'(TVEC);
    if (live) begin
      if (f_any) begin
        // own fault: instruction restarts from its own PC
        trap_wr = 1'b1;
        redir_n = 1'b1;
        sbrm_n  = (int'(f_stg) >= RF_STAGE);
        cause_d = ext_irq ? CW'(CODE_EXT) : f_code;
      end else if (ext_irq && (is_scall || eret_ok)) begin
        trap_wr = 1'b1;
        redir_n = 1'b1;
      end else if (ext_irq) begin
        // clean: retire, then take the interrupt after it
        commit_n = 1'b1;
        sbrm_n   = 1'b1;
        trap_wr  = 1'b1;
        redir_n  = 1'b1;
        epc_d    = cm_ppc;
      end else if (is_scall) begin
        commit_n = 1'b1;
        sbrm_n   = 1'b1;
        trap_wr  = 1'b1;
        redir_n  = 1'b1;
        cause_d  = CW'(CODE_SCALL);
      end else if (eret_ok) begin
        commit_n = 1'b1;
        sbrm_n   = 1'b1;
        do_pop   = 1'b1;
        redir_n  = 1'b1;
        rtgt_n   = epc_q;
      end else begin
        commit_n = 1'b1;
        sbrm_n   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_en <= 1'b0;
      sb_remove <= 1'b0;
      redir_vld <= 1'b0;
      redir_pc  <= '0;
    end else begin
      commit_en <= commit_n;
      sb_remove <= sbrm_n;
      redir_vld <= redir_n;
      redir_pc  <= redir_n ? rtgt_n : '0;
    end
  end

endmodule

// File: rtl/exc_commit_chk.sv
module exc_commit_chk #(
  parameter int XLEN = 32,
  parameter int NSTG = 4,
  parameter int CW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            cm_valid,
  input logic            cm_epoch,
  input logic [XLEN-1:0] cm_pc,
  input logic [XLEN-1:0] cm_ppc,
  input logic [1:0]      cm_kind,
  input logic [NSTG-1:0] flt_vld,
  input logic            ext_irq,
  input logic            commit_en,
  input logic            sb_remove,
  input logic            redir_vld,
  input logic [XLEN-1:0] redir_pc,
  input logic            epoch,
  input logic [XLEN-1:0] epc_q,
  input logic [CW-1:0]   cause_q,
  input logic [1:0]      status_q
);

  logic live;
  assign live = cm_valid && (cm_epoch == epoch);

  p_stale_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (cm_valid && cm_epoch != epoch) |=> (!commit_en && !redir_vld && !sb_remove
                                         && $stable(epc_q) && $stable(cause_q)));

  p_redir_flip_r10: assert property (@(posedge clk) disable iff (rst)
    redir_vld |-> (epoch != $past(epoch)));

  p_idle_irq_r11: assert property (@(posedge clk) disable iff (rst)
    !cm_valid |=> (!commit_en && !redir_vld && $stable(status_q) && $stable(cause_q)));

  p_scall_r7: assert property (@(posedge clk) disable iff (rst)
    (live && cm_kind == 2'd1 && flt_vld == '0 && !ext_irq)
      |=> (commit_en && redir_vld && cause_q == CW'(8) && epc_q == $past(cm_pc)));

  p_fault_trap_r4: assert property (@(posedge clk) disable iff (rst)
    (live && flt_vld != '0)
      |=> (!commit_en && redir_vld && status_q[0] && epc_q == $past(cm_pc)));

  p_irq_clean_r6: assert property (@(posedge clk) disable iff (rst)
    (live && flt_vld == '0 && cm_kind == 2'd0 && ext_irq)
      |=> (commit_en && sb_remove && redir_vld && epc_q == $past(cm_ppc) && cause_q == '0));

  p_redir_target_r8: assert property (@(posedge clk) disable iff (rst)
    !redir_vld |-> (redir_pc == '0));

endmodule

bind exc_commit_unit exc_commit_chk #(.XLEN(XLEN), .NSTG(NSTG), .CW(CW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cm_valid  (cm_valid),
  .cm_epoch  (cm_epoch),
  .cm_pc     (cm_pc),
  .cm_ppc    (cm_ppc),
  .cm_kind   (cm_kind),
  .flt_vld   (flt_vld),
  .ext_irq   (ext_irq),
  .commit_en (commit_en),
  .sb_remove (sb_remove),
  .redir_vld (redir_vld),
  .redir_pc  (redir_pc),
  .epoch     (epoch),
  .epc_q     (epc_q),
  .cause_q   (cause_q),
  .status_q  (status_q)
);

// File: tb/test_exc_commit_unit.sv
module test_exc_commit_unit;

  localparam int          XLEN = 32;
  localparam int          NSTG = 4;
  localparam int          CW   = 5;
  localparam logic [31:0] TVEC = 32'h0000_0100;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cm_valid = 1'b0;
  logic              cm_epoch = 1'b0;
  logic [XLEN-1:0]   cm_pc = '0;
  logic [XLEN-1:0]   cm_ppc = '0;
  logic [1:0]        cm_kind = '0;
  logic [NSTG-1:0]   flt_vld = '0;
  logic [NSTG*CW-1:0] flt_code = '0;
  logic              ext_irq = 1'b0;
  logic              commit_en, sb_remove, redir_vld, epoch;
  logic [XLEN-1:0]   redir_pc, epc_q;
  logic [CW-1:0]     cause_q;
  logic [1:0]        status_q;

  always #10 clk = ~clk;  // 50 MHz

  exc_commit_unit i_exc_commit_unit (
    .clk(clk), .rst(rst), .cm_valid(cm_valid), .cm_epoch(cm_epoch),
    .cm_pc(cm_pc), .cm_ppc(cm_ppc), .cm_kind(cm_kind), .flt_vld(flt_vld),
    .flt_code(flt_code), .ext_irq(ext_irq), .commit_en(commit_en),
    .sb_remove(sb_remove), .redir_vld(redir_vld), .redir_pc(redir_pc),
    .epoch(epoch), .epc_q(epc_q), .cause_q(cause_q), .status_q(status_q)
  );

  typedef struct {
    string       tag;
    logic        cm, sb, rd;
    logic [31:0] rpc;
    logic        ep;
    logic [31:0] epc;
    logic [4:0]  cause;
    logic [1:0]  st;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  // requirement-level model state
  logic        m_cur = 1'b1, m_prv = 1'b0, m_ep = 1'b0;
  logic [31:0] m_epc = '0;
  logic [4:0]  m_cause = '0;

  task automatic drive(input string tag, input logic v, input logic stale,
                       input logic [31:0] pc, input logic [31:0] ppc,
                       input logic [1:0] kind, input logic [3:0] fv,
                       input logic [19:0] fc, input logic irq);
    exp_t e;
    logic live, any, noperm, sysi, trap, pop;
    logic [4:0] code;
    int wst;
    @(negedge clk);
    cm_valid = v; cm_epoch = stale ? ~m_ep : m_ep; cm_pc = pc; cm_ppc = ppc;
    cm_kind = kind; flt_vld = fv; flt_code = fc; ext_irq = irq;
    live = v && !stale;
    noperm = (kind == 2'd2) && !m_cur;
    any = 1'b0; code = '0; wst = 0;
    for (int s = NSTG - 1; s >= 0; s--) begin
      if (fv[s]) begin any = 1'b1; code = fc[s*CW +: CW]; wst = s; end
      else if (s == 1 && noperm) begin any = 1'b1; code = 5'h0B; wst = 1; end
    end
    sysi = (kind == 2'd1) || (kind == 2'd2 && m_cur);
    e.tag = tag; e.cm = 0; e.sb = 0; e.rd = 0; e.rpc = TVEC;
    trap = 0; pop = 0;
    if (live) begin
      if (any) begin
        trap = 1; e.sb = (wst >= 2); m_epc = pc; m_cause = irq ? 5'h00 : code;
      end else if (irq && sysi) begin
        trap = 1; m_epc = pc; m_cause = 5'h00;
      end else if (irq) begin
        e.cm = 1; e.sb = 1; trap = 1; m_epc = ppc; m_cause = 5'h00;
      end else if (kind == 2'd1) begin
        e.cm = 1; e.sb = 1; trap = 1; m_epc = pc; m_cause = 5'h08;
      end else if (kind == 2'd2) begin
        e.cm = 1; e.sb = 1; pop = 1; e.rpc = m_epc;
      end else begin
        e.cm = 1; e.sb = 1;
      end
    end
    if (trap) begin m_prv = m_cur; m_cur = 1'b1; end
    if (pop) m_cur = m_prv;
    e.rd = trap || pop;
    if (e.rd) m_ep = ~m_ep;
    e.ep = m_ep; e.epc = m_epc; e.cause = m_cause; e.st = {m_prv, m_cur};
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag, input logic irq);
    drive(tag, 1'b0, 1'b0, 32'h0, 32'h0, 2'd0, 4'h0, 20'h0, irq);
  endtask

  // monitor: one expected item per cycle, compared just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        logic [31:0] arpc;
        e = exp_q.pop_front();
        arpc = e.rd ? redir_pc : e.rpc;
        n_chk++;
        if ({commit_en, sb_remove, redir_vld, epoch, cause_q, status_q} !==
            {e.cm, e.sb, e.rd, e.ep, e.cause, e.st} ||
            epc_q !== e.epc || arpc !== e.rpc) begin
          n_fail++;
          $display("FAIL %s: got cm=%b sb=%b rd=%b rpc=%h ep=%b epc=%h cause=%h st=%b, exp cm=%b sb=%b rd=%b rpc=%h ep=%b epc=%h cause=%h st=%b",
                   e.tag, commit_en, sb_remove, redir_vld, arpc, epoch, epc_q, cause_q, status_q,
                   e.cm, e.sb, e.rd, e.rpc, e.ep, e.epc, e.cause, e.st);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    idle("R1 reset", 1'b0);
    drive("R2 ordinary", 1, 0, 32'h1000, 32'h1004, 2'd0, 4'h0, 20'h0, 0);
    drive("R2 reserved kind", 1, 0, 32'h1004, 32'h1008, 2'd3, 4'h0, 20'h0, 0);
    drive("R8 return kernel", 1, 0, 32'h1008, 32'h100C, 2'd2, 4'h0, 20'h0, 0);
    drive("R10 stale dropped", 1, 1, 32'h100C, 32'h1010, 2'd1, 4'h0, 20'h0, 0);
    drive("R3 fetch beats noperm", 1, 0, 32'h2000, 32'h2004, 2'd2, 4'b0001, 20'h0000A, 0);
    drive("R8 return again", 1, 0, 32'h2100, 32'h2104, 2'd2, 4'h0, 20'h0, 0);
    drive("R8 return user noperm", 1, 0, 32'h2200, 32'h2204, 2'd2, 4'h0, 20'h0, 0);
    drive("R7 syscall", 1, 0, 32'h3000, 32'h3004, 2'd1, 4'h0, 20'h0, 0);
    drive("R4 exec overflow", 1, 0, 32'h3100, 32'h3104, 2'd0, 4'b0100, {5'h0, 5'h0C, 5'h0, 5'h0}, 0);
    drive("R3 decode beats memory", 1, 0, 32'h3200, 32'h3204, 2'd0, 4'b1010, {5'h0C, 5'h0, 5'h0A, 5'h0}, 0);
    drive("R4 memory fault", 1, 0, 32'h3300, 32'h3304, 2'd0, 4'b1000, {5'h0C, 5'h0, 5'h0, 5'h0}, 0);
    drive("R6 clean with irq", 1, 0, 32'h4000, 32'h4040, 2'd0, 4'h0, 20'h0, 1);
    drive("R5 fault with irq", 1, 0, 32'h4100, 32'h4104, 2'd0, 4'b0100, {5'h0, 5'h0C, 5'h0, 5'h0}, 1);
    drive("R9 syscall with irq", 1, 0, 32'h4200, 32'h4204, 2'd1, 4'h0, 20'h0, 1);
    idle("R11 irq while idle", 1'b1);
    drive("R2 after irq", 1, 0, 32'h5000, 32'h5004, 2'd0, 4'h0, 20'h0, 0);
    idle("R1 quiet", 1'b0);
    idle("R11 quiet", 1'b0);
    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule